// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address for 4 KB pages. It does this by reading a two-level translation structure held in memory. A requester presents a virtual address with a read/write flag and a user/supervisor flag on a valid/ready handshake. The walker then issues at most two word reads over a single-outstanding memory read port. The first read fetches a directory entry. The second fetches a table entry. The walker then presents either the physical address or a fault with a two-bit cause for one cycle.

The physical page of the directory comes from a base register. That register is loaded through a one-cycle write strobe, which takes effect only while the walker is idle. Each entry carries a 20-bit frame number in bits [31:12] and flags in the low bits: bit 0 present, bit 1 writable, bit 2 user-accessible. A permission failure found in the directory entry ends the walk at once, without reading the table entry.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and directly after it, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk targets `{base[31:12], va[31:22], 2'b00}`. The second read targets `{dir_entry[31:12], va[21:12], 2'b00}`.
- R3: A walk that passes every check answers with `rsp_fault` = 0 and `rsp_pa` = `{table_entry[31:12], va[11:0]}`. It performs exactly two memory reads.
- R4: A directory entry with bit 0 (present) clear gives a fault with cause 0, after exactly one read.
- R5: A present directory entry followed by a table entry with bit 0 clear gives a fault with cause 1, after two reads.
- R6: A write access faults with cause 2 when bit 1 (writable) is clear in either entry. If the directory entry already fails this check, the walk stops after one read, even when the table entry would be absent.
- R7: A user access faults with cause 3 when bit 2 (user) is clear in either entry. Supervisor accesses ignore bit 2. Within one entry the order is present first, then write (cause 2), then user (cause 3).
- R8: A base write is taken only while the walker is idle. A write strobe during a walk leaves the base unchanged. Only `base_wdata[31:12]` is kept.
- R9: `req_ready` is 1 only when idle, so one walk runs at a time. `rsp_valid` is a single-cycle pulse, and the walker is idle again in the following cycle.
- R10: A memory read request keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen. A response is taken only after its request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and taking a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| base_we | input | 1 | Directory base write strobe |
| base_wdata | input | 32 | Directory base value (bits [31:12] kept) |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Completion is a fault |
| rsp_cause | output | 2 | Fault cause: 0 directory absent, 1 table absent, 2 write-protect, 3 user-privilege |
| rsp_pa | output | 32 | Translated physical address (valid when no fault) |

## Verification
The bench builds the walker with its default split of 32 address bits, a 12-bit offset and 10-bit indices. The full directory index range is therefore reachable. This includes an entry at index 0x200, above the half-way point of the virtual space, and tables placed at arbitrary frames. The memory model stalls `mem_req_ready` on a pseudo-random pattern, so held requests and back-to-back walks queued behind a busy walker are both exercised. A second base value with junk in its low bits shows that only the frame part of a base write is kept.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PDE,
        S_PTE,
        S_DONE,
        S_FAULT
    } walk_state_e;

    localparam logic [1:0] CAUSE_DIR_ABSENT = 2'd0;
    localparam logic [1:0] CAUSE_TBL_ABSENT = 2'd1;
    localparam logic [1:0] CAUSE_WRITE      = 2'd2;
    localparam logic [1:0] CAUSE_USER       = 2'd3;

    localparam int FLAG_PRESENT  = 0;
    localparam int FLAG_WRITABLE = 1;
    localparam int FLAG_USER     = 2;
    localparam int FLAG_W        = 3;

endpackage

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
// Forms the byte address of a directory or table entry.
// Requires OFF_W - IDX_W to equal log2 of the entry size in bytes.
module ptw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] dir_frame,
    input  logic [ADDR_W-OFF_W-1:0] tbl_frame,
    input  logic [ADDR_W-OFF_W-1:0] vpn,
    input  logic                    use_table,
    output logic [ADDR_W-1:0]       addr
);
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int PAD_W   = OFF_W - IDX_W;

    always_comb begin
        if (use_table) begin
            addr = {tbl_frame, vpn[IDX_W-1:0], {PAD_W{1'b0}}};
        end else begin
            addr = {dir_frame, vpn[FRAME_W-1:FRAME_W-IDX_W], {PAD_W{1'b0}}};
        end
    end
endmodule

// File: rtl/ptw_perm_check.sv
`timescale 1ns/1ps
// Checks one entry's flags against the access; present, then write, then user.
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic              is_write,
    input  logic              is_user,
    input  logic              at_table,
    output logic              fault,
    output logic [1:0]        cause
);
    always_comb begin
        fault = 1'b1;
        cause = CAUSE_DIR_ABSENT;
        if (!flags[FLAG_PRESENT]) begin
            cause = at_table ? CAUSE_TBL_ABSENT : CAUSE_DIR_ABSENT;
        end else if (is_write && !flags[FLAG_WRITABLE]) begin
            cause = CAUSE_WRITE;
        end else if (is_user && !flags[FLAG_USER]) begin
            cause = CAUSE_USER;
        end else begin
            fault = 1'b0;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [ADDR_W-1:0] rsp_pa
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    typedef struct packed {
        walk_state_e        st;
        logic               issued;
        logic [FRAME_W-1:0] base;
        logic [FRAME_W-1:0] pde;
        logic [ADDR_W-1:0]  va;
        logic               wr;
        logic               usr;
        logic [ADDR_W-1:0]  pa;
        logic [1:0]         cause;
    } walk_regs_t;

    walk_regs_t q, d;

    logic       chk_fault;
    logic [1:0] chk_cause;
    logic       unused_low;

    assign unused_low = ^{base_wdata[OFF_W-1:0], mem_rsp_data[OFF_W-1:FLAG_W]};

    ptw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
        .dir_frame (q.base),
        .tbl_frame (q.pde),
        .vpn       (q.va[ADDR_W-1:OFF_W]),
        .use_table (q.st == S_PTE),
        .addr      (mem_req_addr)
    );

    ptw_perm_check u_perm (
        .flags    (mem_rsp_data[FLAG_W-1:0]),
        .is_write (q.wr),
        .is_user  (q.usr),
        .at_table (q.st == S_PTE),
        .fault    (chk_fault),
        .cause    (chk_cause)
    );

    assign req_ready     = (q.st == S_IDLE);
    assign mem_req_valid = (q.st == S_PDE || q.st == S_PTE) && !q.issued;
    assign rsp_valid     = (q.st == S_DONE) || (q.st == S_FAULT);
    assign rsp_fault     = (q.st == S_FAULT);
    assign rsp_cause     = q.cause;
    assign rsp_pa        = q.pa;

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (base_we) begin
                    d.base = base_wdata[ADDR_W-1:OFF_W];
                end
                if (req_valid) begin
                    d.va     = req_va;
                    d.wr     = req_write;
                    d.usr    = req_user;
                    d.issued = 1'b0;
                    d.st     = S_PDE;
                end
            end
            S_PDE, S_PTE: begin
                if (!q.issued && mem_req_ready) begin
                    d.issued = 1'b1;
                end
                if (q.issued && mem_rsp_valid) begin
                    if (chk_fault) begin
                        d.cause = chk_cause;
                        d.st    = S_FAULT;
                    end else if (q.st == S_PDE) begin
                        d.pde    = mem_rsp_data[ADDR_W-1:OFF_W];
                        d.issued = 1'b0;
                        d.st     = S_PTE;
                    end else begin
                        d.pa = {mem_rsp_data[ADDR_W-1:OFF_W], q.va[OFF_W-1:0]};
                        d.st = S_DONE;
                    end
                end
            end
            S_DONE, S_FAULT: d.st = S_IDLE;
            default:         d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    // R9
    pulse_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R8
    base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_we && !req_ready) |=> $stable(q.base));

    // R4
    dir_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PDE && q.issued && mem_rsp_valid && !mem_rsp_data[FLAG_PRESENT])
        |=> (rsp_valid && rsp_fault && rsp_cause == CAUSE_DIR_ABSENT));

    // R5
    tbl_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PTE && q.issued && mem_rsp_valid && !mem_rsp_data[FLAG_PRESENT])
        |=> (rsp_valid && rsp_fault && rsp_cause == CAUSE_TBL_ABSENT));

    // R3
    pa_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PTE && q.issued && mem_rsp_valid && !chk_fault)
        |=> (rsp_valid && !rsp_fault &&
             rsp_pa == {$past(mem_rsp_data[ADDR_W-1:OFF_W]), q.va[OFF_W-1:0]}));
endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_pa;

    always #2 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user),
        .base_we(base_we), .base_wdata(base_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_pa(rsp_pa)
    );

    typedef struct {
        logic        fault;
        logic [1:0]  cause;
        logic [31:0] pa;
        int          reads;
        string       req;
    } exp_t;

    logic [31:0] mem [logic [31:0]];
    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    logic [31:0] model_base = '0;
    int          errors = 0;
    int          checks = 0;
    int          reads_total = 0;
    int          reads_mark = 0;
    int          cycles = 0;
    logic [4:0]  lfsr = 5'h1F;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic        prev_rsp = 1'b0;
    exp_t        ex;
    logic [31:0] ea;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // memory model: one-cycle read latency, pseudo-random acceptance stalls
    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr          <= 5'h1F;
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
        end else begin
            lfsr          <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
            mem_req_ready <= lfsr[0] | lfsr[3];
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(mem_req_addr);
                reads_total   <= reads_total + 1;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (prev_stall)
                chk(mem_req_valid && mem_req_addr == prev_addr, "R10", "held read request",
                    mem_req_addr, prev_addr);
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                if (addr_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected read", mem_req_addr, 32'h0);
                end else begin
                    ea = addr_q.pop_front();
                    chk(mem_req_addr == ea, "R2", "entry address", mem_req_addr, ea);
                end
            end
            if (rsp_valid) begin
                chk(!req_ready, "R9", "ready during response", {31'h0, req_ready}, 32'h0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected response", rsp_pa, 32'h0);
                end else begin
                    ex = exp_q.pop_front();
                    chk(rsp_fault == ex.fault, ex.req, "fault flag",
                        {31'h0, rsp_fault}, {31'h0, ex.fault});
                    if (ex.fault)
                        chk(rsp_cause == ex.cause, ex.req, "fault cause",
                            {30'h0, rsp_cause}, {30'h0, ex.cause});
                    else
                        chk(rsp_pa == ex.pa, ex.req, "physical address", rsp_pa, ex.pa);
                    chk(reads_total - reads_mark == ex.reads, ex.req, "memory reads",
                        reads_total - reads_mark, ex.reads);
                end
                reads_mark = reads_total;
            end else if (prev_rsp) begin
                chk(req_ready, "R9", "idle after response", {31'h0, req_ready}, 32'h1);
            end
            prev_rsp = rsp_valid;
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // expected result straight from the requirements
    task automatic model(input logic [31:0] va, input bit wr, input bit usr, input string tag);
        exp_t        e;
        logic [31:0] pa1, pa2, pde, pte;
        e.req = tag; e.fault = 1'b1; e.cause = 2'd0; e.pa = '0;
        pa1 = {model_base[31:12], va[31:22], 2'b00};
        addr_q.push_back(pa1);
        pde = rd(pa1);
        e.reads = 1;
        if (!pde[0])             e.cause = 2'd0;
        else if (wr && !pde[1])  e.cause = 2'd2;
        else if (usr && !pde[2]) e.cause = 2'd3;
        else begin
            pa2 = {pde[31:12], va[21:12], 2'b00};
            addr_q.push_back(pa2);
            pte = rd(pa2);
            e.reads = 2;
            if (!pte[0])             e.cause = 2'd1;
            else if (wr && !pte[1])  e.cause = 2'd2;
            else if (usr && !pte[2]) e.cause = 2'd3;
            else begin
                e.fault = 1'b0;
                e.pa    = {pte[31:12], va[11:0]};
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic send(input logic [31:0] va, input bit wr, input bit usr, input string tag);
        model(va, wr, usr, tag);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        base_we = 1'b1; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
        model_base = v;
    endtask

    initial begin
        // base A = 0x00010000
        mem[32'h0001_0004] = 32'h0002_0007;
        mem[32'h0001_000C] = 32'h0003_0005;
        mem[32'h0001_0800] = 32'h0004_0003;
        mem[32'h0002_0014] = 32'h1234_5007;
        mem[32'h0002_001C] = 32'h0AAA_A005;
        mem[32'h0002_0020] = 32'h0BBB_B003;
        mem[32'h0002_0024] = 32'h0CCC_C001;
        mem[32'h0004_0004] = 32'h0010_0003;
        // base B = 0x00050000
        mem[32'h0005_0004] = 32'h0006_0007;
        mem[32'h0006_0014] = 32'h7777_7007;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready in reset", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", {31'h0, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !rsp_valid && !mem_req_valid, "R1", "state after reset",
            {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

        set_base(32'h0001_0000);
        send(32'h0040_5ABC, 1'b0, 1'b0, "R3");
        send(32'h0040_5123, 1'b1, 1'b1, "R3");
        send(32'h8000_1FFC, 1'b1, 1'b0, "R3");
        send(32'h0080_0000, 1'b0, 1'b0, "R4");
        send(32'h0040_6000, 1'b0, 1'b0, "R5");
        send(32'h0040_7000, 1'b1, 1'b0, "R6");
        send(32'h0040_7010, 1'b0, 1'b1, "R6");
        send(32'h00C0_0000, 1'b1, 1'b0, "R6");
        send(32'h00C0_0000, 1'b0, 1'b1, "R5");
        send(32'h0040_8000, 1'b0, 1'b1, "R7");
        send(32'h0040_8000, 1'b1, 1'b0, "R7");
        send(32'h0040_9000, 1'b1, 1'b1, "R7");
        send(32'h8000_0000, 1'b0, 1'b1, "R7");

        // R8: base strobe during a walk must be dropped
        send(32'h0040_5ABC, 1'b0, 1'b0, "R8");
        base_we = 1'b1; base_wdata = 32'h0005_0000;
        @(negedge clk);
        base_we = 1'b0;
        send(32'h0040_5ABC, 1'b0, 1'b0, "R8");
        // R8: idle write, low bits discarded
        set_base(32'h0005_0ABC);
        send(32'h0040_5ABC, 1'b0, 1'b0, "R8");

        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all walks answered", exp_q.size(), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule